// File: doc/BRIEF.md
# Charge Timing and Pulse Modulator

This block sets the timing of one battery charging channel. Two three-state strap inputs (low, float, high) choose one of nine rate settings. Each setting fixes three things together: the limit on charge time, the length of the window at the start of fast charge during which the voltage-drop test is held off, and whether a top-off phase is allowed. The surrounding charge controller picks the phase (idle, pending, fast, top-off or maintenance). From that phase and the setting, the block drives the gate of the charge switch and reports the timeout and hold-off status.

All durations are counted in ticks of a prescaled `tick` strobe. Parameters scale these counts: one for minutes, one for seconds, and two for the on time and period of the trickle pulse. The on/off pattern in top-off is fixed at 4 on and 30 off, in second units. Any change of phase restarts the modulation pattern, the timer and the hold-off counter.

Top module: `chgtime_mod`

## Requirements
- R1: The strap pair is indexed as idx = pin1 + 3*pin2, with the codes 00 = low (0), 01 = float (1) and 10 = high (2). The time limits in minutes for idx 0..8 are 360, 180, 90, 45, 23, 180, 90, 45, 23. In fast charge, `timeoutFlag` rises exactly when the number of ticks counted reaches limit*MIN_TICKS.
- R2: The hold-off lengths in seconds for idx 0..8 are 137, 820, 410, 200, 100, 820, 410, 200, 100. `holdoffActive` is high from the first cycle of fast charge until holdSec*SEC_TICKS ticks have been counted. It is low in every other phase.
- R3: Top-off is allowed only for idx 5..8. With idx 0..4, the gate stays low throughout the top-off phase.
- R4: In fast charge the gate is high for as long as `timeoutFlag` is low. While `timeoutFlag` is high, in fast charge or in top-off, the gate is low.
- R5: In top-off (when allowed), the gate is high for the first TOP_ON_SEC*SEC_TICKS ticks of each period of (TOP_ON_SEC+TOP_OFF_SEC)*SEC_TICKS ticks. The pattern begins in its on part when the phase is entered.
- R6: In pending and maintenance, the gate is high for TRK_ON_TICKS ticks at the start of each trickle period. The period is TRK_PERIOD_TICKS when top-off is not allowed and twice that when it is. With both straps low (idx 0), no trickle pulse is produced.
- R7: The charge timer is cleared when fast charge is left and counts again, against the same limit, in top-off. `timeoutFlag` is never high in idle, pending or maintenance.
- R8: A change on `phase` clears the modulation count, the timer and the hold-off count. A tick that arrives in the same cycle as the change is not counted.
- R9: During reset, `gate`, `timeoutFlag` and `holdoffActive` are all low.
- R10: The strap code 11 is decoded as float. Phase codes 5..7 act as idle. The phase codes are 0 idle, 1 pending, 2 fast, 3 top-off, 4 maintenance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled time strobe, one count per high cycle |
| cfgPin1 | input | 2 | First strap state (00 low, 01 float, 10 high) |
| cfgPin2 | input | 2 | Second strap state (same coding) |
| phase | input | 3 | Charge phase selected by the controller |
| gate | output | 1 | Charge switch enable |
| timeoutFlag | output | 1 | Charge time limit reached in the current fast or top-off phase |
| holdoffActive | output | 1 | Voltage-drop test is being held off |

## Verification
A phase change and a tick can fall in the same cycle. When they do, the restart takes precedence and the tick is lost. The bench provokes this by entering fast charge and maintenance with `tick` held high on the cycle of the change. It then checks that the timeout appears only after the full limit of further ticks, and that the trickle pattern starts from its first on tick. A second collision happens when the timer expires: the gate must drop in the very cycle `timeoutFlag` rises. The bench samples both signals together on that tick.

// File: rtl/chgtime_pkg.sv
package chgtime_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PEND  = 3'd1,
    PH_FAST  = 3'd2,
    PH_TOP   = 3'd3,
    PH_MAINT = 3'd4
  } phaseT;

  // control-to-datapath strobes
  typedef struct packed {
    logic restart;
    logic tick;
    logic inFast;
    logic inTop;
    logic inTrk;
  } strobeT;

  // strap code 11 folds onto float (R10)
  function automatic logic [1:0] pinLevel(input logic [1:0] p);
    return (p == 2'b11) ? 2'b01 : p;
  endfunction

  function automatic logic [3:0] cfgIndex(input logic [1:0] a, input logic [1:0] b);
    logic [3:0] ia, ib;
    ia = {2'b00, pinLevel(a)};
    ib = {2'b00, pinLevel(b)};
    return ia + 4'd3 * ib;
  endfunction

  function automatic logic [8:0] limitMinutes(input logic [3:0] idx);
    case (idx)
      4'd0:           return 9'd360;
      4'd1, 4'd5:     return 9'd180;
      4'd2, 4'd6:     return 9'd90;
      4'd3, 4'd7:     return 9'd45;
      default:        return 9'd23;
    endcase
  endfunction

  function automatic logic [9:0] holdSeconds(input logic [3:0] idx);
    case (idx)
      4'd0:           return 10'd137;
      4'd1, 4'd5:     return 10'd820;
      4'd2, 4'd6:     return 10'd410;
      4'd3, 4'd7:     return 10'd200;
      default:        return 10'd100;
    endcase
  endfunction

endpackage

// File: rtl/chgtime_ctrl.sv
module chgtime_ctrl
  import chgtime_pkg::*;
#(
  parameter int MIN_TICKS        = 60,
  parameter int SEC_TICKS        = 1,
  parameter int TOP_ON_SEC       = 4,
  parameter int TOP_OFF_SEC      = 30,
  parameter int TRK_ON_TICKS     = 1,
  parameter int TRK_PERIOD_TICKS = 8,
  parameter int TW               = 16,
  parameter int HW               = 10,
  parameter int MW               = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickIn,
  input  logic [1:0]    pinA,
  input  logic [1:0]    pinB,
  input  logic [2:0]    phaseIn,
  output strobeT        stb,
  output logic [TW-1:0] tmrLimit,
  output logic [HW-1:0] hoLimit,
  output logic [MW-1:0] modPeriod,
  output logic [MW-1:0] modOn,
  output logic          topEn,
  output logic          trkEn
);

  localparam int TOP_PERIOD = (TOP_ON_SEC + TOP_OFF_SEC) * SEC_TICKS;
  localparam int TOP_ON     = TOP_ON_SEC * SEC_TICKS;

  phaseT      phaseNorm, phaseQ;
  logic [3:0] idx;

  always_comb begin
    case (phaseIn)
      3'd1:    phaseNorm = PH_PEND;
      3'd2:    phaseNorm = PH_FAST;
      3'd3:    phaseNorm = PH_TOP;
      3'd4:    phaseNorm = PH_MAINT;
      default: phaseNorm = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseNorm;
  end

  assign idx      = cfgIndex(pinA, pinB);
  assign topEn    = (idx >= 4'd5);
  assign trkEn    = (idx != 4'd0);
  assign tmrLimit = TW'(int'(limitMinutes(idx)) * MIN_TICKS);
  assign hoLimit  = HW'(int'(holdSeconds(idx)) * SEC_TICKS);

  always_comb begin
    stb.restart = (phaseNorm != phaseQ);
    stb.tick    = tickIn;
    stb.inFast  = (phaseQ == PH_FAST);
    stb.inTop   = (phaseQ == PH_TOP);
    stb.inTrk   = (phaseQ == PH_PEND) || (phaseQ == PH_MAINT);
    if (stb.inTrk) begin
      modOn     = MW'(TRK_ON_TICKS);
      modPeriod = topEn ? MW'(2 * TRK_PERIOD_TICKS) : MW'(TRK_PERIOD_TICKS);
    end else begin
      modOn     = MW'(TOP_ON);
      modPeriod = MW'(TOP_PERIOD);
    end
  end

  // at most one phase region is active at a time (R10)
  assert_one_region_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.inFast, stb.inTop, stb.inTrk}))
    else $error("phase regions overlap");

endmodule

// File: rtl/chgtime_dp.sv
module chgtime_dp
  import chgtime_pkg::*;
#(
  parameter int TW = 16,
  parameter int HW = 10,
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  input  logic [TW-1:0] tmrLimit,
  input  logic [HW-1:0] hoLimit,
  input  logic [MW-1:0] modPeriod,
  input  logic [MW-1:0] modOn,
  input  logic          topEn,
  input  logic          trkEn,
  output logic          gate,
  output logic          timeoutFlag,
  output logic          holdoffActive
);

  logic [TW-1:0] tmrCnt;
  logic [HW-1:0] hoCnt;
  logic [MW-1:0] modCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
      hoCnt  <= '0;
      modCnt <= '0;
    end else if (stb.restart) begin
      tmrCnt <= '0;
      hoCnt  <= '0;
      modCnt <= '0;
    end else if (stb.tick) begin
      if ((stb.inFast || stb.inTop) && (tmrCnt < tmrLimit))
        tmrCnt <= tmrCnt + 1'b1;
      if (stb.inFast && (hoCnt < hoLimit))
        hoCnt <= hoCnt + 1'b1;
      if (stb.inTop || stb.inTrk)
        modCnt <= (modCnt >= modPeriod - 1'b1) ? '0 : modCnt + 1'b1;
    end
  end

  assign timeoutFlag   = (stb.inFast || stb.inTop) && (tmrCnt >= tmrLimit);
  assign holdoffActive = stb.inFast && (hoCnt < hoLimit);

  always_comb begin
    if (stb.inFast)      gate = !timeoutFlag;
    else if (stb.inTop)  gate = topEn && !timeoutFlag && (modCnt < modOn);
    else if (stb.inTrk)  gate = trkEn && (modCnt < modOn);
    else                 gate = 1'b0;
  end

  assert_timeout_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !stb.restart) |=> timeoutFlag)
    else $error("timeout dropped inside a phase");

  assert_gate_cut_R4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> !gate)
    else $error("gate high after timeout");

  assert_holdoff_once_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!holdoffActive && stb.inFast && !stb.restart) |=> !holdoffActive)
    else $error("hold-off reopened in fast charge");

  assert_no_trickle_timeout_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.inTrk |-> !timeoutFlag)
    else $error("timeout in trickle");

  assert_mod_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inTop || stb.inTrk) |-> (modCnt < modPeriod))
    else $error("modulation count out of period");

endmodule

// File: rtl/chgtime_mod.sv
module chgtime_mod
  import chgtime_pkg::*;
#(
  parameter int MIN_TICKS        = 60,
  parameter int SEC_TICKS        = 1,
  parameter int TOP_ON_SEC       = 4,
  parameter int TOP_OFF_SEC      = 30,
  parameter int TRK_ON_TICKS     = 1,
  parameter int TRK_PERIOD_TICKS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] cfgPin1,
  input  logic [1:0] cfgPin2,
  input  logic [2:0] phase,
  output logic       gate,
  output logic       timeoutFlag,
  output logic       holdoffActive
);

  localparam int MAX_TMR = 360 * MIN_TICKS;
  localparam int MAX_HO  = 820 * SEC_TICKS;
  localparam int TOP_P   = (TOP_ON_SEC + TOP_OFF_SEC) * SEC_TICKS;
  localparam int TRK_P2  = 2 * TRK_PERIOD_TICKS;
  localparam int MAX_P   = (TOP_P > TRK_P2) ? TOP_P : TRK_P2;
  localparam int TW      = $clog2(MAX_TMR + 1);
  localparam int HW      = $clog2(MAX_HO + 1);
  localparam int MW      = $clog2(MAX_P + 1);

  strobeT        stb;
  logic [TW-1:0] tmrLimit;
  logic [HW-1:0] hoLimit;
  logic [MW-1:0] modPeriod, modOn;
  logic          topEn, trkEn;

  chgtime_ctrl #(
    .MIN_TICKS(MIN_TICKS), .SEC_TICKS(SEC_TICKS),
    .TOP_ON_SEC(TOP_ON_SEC), .TOP_OFF_SEC(TOP_OFF_SEC),
    .TRK_ON_TICKS(TRK_ON_TICKS), .TRK_PERIOD_TICKS(TRK_PERIOD_TICKS),
    .TW(TW), .HW(HW), .MW(MW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .tickIn(tick), .pinA(cfgPin1), .pinB(cfgPin2),
    .phaseIn(phase), .stb(stb), .tmrLimit(tmrLimit), .hoLimit(hoLimit),
    .modPeriod(modPeriod), .modOn(modOn), .topEn(topEn), .trkEn(trkEn)
  );

  chgtime_dp #(.TW(TW), .HW(HW), .MW(MW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .tmrLimit(tmrLimit), .hoLimit(hoLimit),
    .modPeriod(modPeriod), .modOn(modOn), .topEn(topEn), .trkEn(trkEn),
    .gate(gate), .timeoutFlag(timeoutFlag), .holdoffActive(holdoffActive)
  );

endmodule

// File: tb/sim_chgtime_mod.sv
module sim_chgtime_mod;
  localparam int MINT = 2, SECT = 1, TON = 4, TOFF = 30, TRKON = 2, TRKP = 8;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic [1:0] p1 = 2'b00, p2 = 2'b00;
  logic [2:0] phase = 3'd0;
  logic gate, tmo, hold;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  chgtime_mod #(.MIN_TICKS(MINT), .SEC_TICKS(SECT), .TOP_ON_SEC(TON),
                .TOP_OFF_SEC(TOFF), .TRK_ON_TICKS(TRKON), .TRK_PERIOD_TICKS(TRKP))
  u0 (.clk(clk), .rstN(rstN), .tick(tick), .cfgPin1(p1), .cfgPin2(p2),
      .phase(phase), .gate(gate), .timeoutFlag(tmo), .holdoffActive(hold));

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic stepT(logic tk);
    tick = tk; @(posedge clk); @(negedge clk); tick = 1'b0;
  endtask

  task automatic runTicks(int n);
    for (int i = 0; i < n; i++) stepT(1'b1);
  endtask

  task automatic enter(logic [2:0] ph, logic tk);
    phase = ph; stepT(tk);
  endtask

  task automatic setPins(logic [1:0] a, logic [1:0] b);
    p1 = a; p2 = b; enter(3'd0, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 gate", gate, 1'b0);
    chk("R9 timeout", tmo, 1'b0);
    chk("R9 holdoff", hold, 1'b0);
    rstN = 1'b1; @(negedge clk);
  endtask

  // tick held high on the phase-change cycle: must be discarded (R8)
  task automatic t_fastTimeout(logic [1:0] a, logic [1:0] b, int minutes, string tag);
    setPins(a, b);
    enter(3'd2, 1'b1);
    chk({tag, " R4 gate on"}, gate, 1'b1);
    runTicks(minutes * MINT - 1);
    chk({tag, " R1 R8 not yet"}, tmo, 1'b0);
    chk({tag, " R4 gate still on"}, gate, 1'b1);
    runTicks(1);
    chk({tag, " R1 timeout"}, tmo, 1'b1);
    chk({tag, " R4 gate cut"}, gate, 1'b0);
  endtask

  task automatic t_holdoff(logic [1:0] a, logic [1:0] b, int secs);
    setPins(a, b);
    chk("R2 idle holdoff low", hold, 1'b0);
    enter(3'd2, 1'b0);
    chk("R2 holdoff at entry", hold, 1'b1);
    runTicks(secs * SECT - 1);
    chk("R2 holdoff before end", hold, 1'b1);
    runTicks(1);
    chk("R2 holdoff ended", hold, 1'b0);
  endtask

  task automatic t_topoffRetime();
    setPins(2'b01, 2'b10);           // idx 7: 45 min, top-off allowed
    enter(3'd2, 1'b0);
    runTicks(45 * MINT);
    chk("R1 fast timeout", tmo, 1'b1);
    enter(3'd3, 1'b0);
    chk("R7 timer cleared", tmo, 1'b0);
    chk("R2 no holdoff in topoff", hold, 1'b0);
    chk("R5 topoff starts on", gate, 1'b1);
    runTicks(45 * MINT - 1);
    chk("R7 topoff not yet", tmo, 1'b0);
    runTicks(1);
    chk("R7 topoff timeout", tmo, 1'b1);
    chk("R4 topoff gate cut", gate, 1'b0);
  endtask

  task automatic t_topoffPattern();
    setPins(2'b00, 2'b10);           // idx 6, top-off allowed, 180 ticks limit
    enter(3'd3, 1'b0);
    for (int k = 0; k <= 100; k++) begin
      chk("R5 topoff pattern", gate, ((k % ((TON + TOFF) * SECT)) < TON * SECT));
      stepT(1'b1);
    end
  endtask

  task automatic t_topoffDisabled();
    setPins(2'b01, 2'b01);           // idx 4, top-off not allowed
    enter(3'd3, 1'b0);
    for (int k = 0; k <= 40; k++) begin
      chk("R3 topoff disabled", gate, 1'b0);
      stepT(1'b1);
    end
  endtask

  task automatic t_trickle(logic [1:0] a, logic [1:0] b, logic [2:0] ph, int period, logic en);
    setPins(a, b);
    enter(ph, 1'b0);
    for (int k = 0; k < 3 * period; k++) begin
      chk("R6 trickle pattern", gate, en && ((k % period) < TRKON));
      stepT(1'b1);
    end
    chk("R7 no trickle timeout", tmo, 1'b0);
  endtask

  task automatic t_restart();
    setPins(2'b01, 2'b01);           // idx 4, period TRKP
    enter(3'd1, 1'b0);
    runTicks(3);
    chk("R6 mid period off", gate, 1'b0);
    enter(3'd4, 1'b1);               // change + tick together
    chk("R8 restart on", gate, 1'b1);
    runTicks(1);
    chk("R8 second on tick", gate, 1'b1);
    runTicks(1);
    chk("R8 off after on", gate, 1'b0);
  endtask

  task automatic t_longMaint();
    setPins(2'b10, 2'b10);           // idx 8: limit 46 ticks
    enter(3'd4, 1'b0);
    runTicks(100);
    chk("R7 maint no timeout", tmo, 1'b0);
    phase = 3'd6; stepT(1'b1);       // code 6 acts as idle
    chk("R10 phase 6 idle gate", gate, 1'b0);
    chk("R10 phase 6 idle timeout", tmo, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fastTimeout(2'b01, 2'b01, 23, "ff");
    t_fastTimeout(2'b10, 2'b10, 23, "hh");
    t_fastTimeout(2'b00, 2'b01, 45, "lf");
    t_fastTimeout(2'b10, 2'b00, 90, "hl");
    t_fastTimeout(2'b10, 2'b01, 180, "hf");
    t_fastTimeout(2'b11, 2'b11, 23, "R10 code11");
    t_holdoff(2'b00, 2'b00, 137);
    t_holdoff(2'b01, 2'b00, 820);
    t_holdoff(2'b01, 2'b10, 200);
    t_topoffRetime();
    t_topoffPattern();
    t_topoffDisabled();
    t_trickle(2'b01, 2'b01, 3'd1, TRKP, 1'b1);
    t_trickle(2'b00, 2'b10, 3'd4, 2 * TRKP, 1'b1);
    t_trickle(2'b00, 2'b00, 3'd1, TRKP, 1'b0);
    t_restart();
    t_longMaint();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule